// File: doc/BRIEF.md
# Serial Bus Slave Function Decoder

This block sits behind the byte layer of a two-wire serial slave. Bit timing, start/stop detection and the acknowledge slot are handled upstream; this block receives start, stop and byte-valid strobes. It looks at the first byte of every transaction and decides whether the device is being addressed. If so, it steers the rest of the transfer to one of four internal function spaces. One of these spaces is a 128-word by 8-bit storage array held inside the block. Two are register spaces (threshold limits and configuration) reached through a simple external register port. The last answers an alert-response query.

The upper four bits of the first byte select the function space. Bits 3 to 1 must match three strap pins, so up to eight such devices can share a bus. Bit 0 gives the direction. An active-low enable pin gates everything: while it is high the block neither acknowledges, writes nor advances. Writes carry a word-address byte followed by data bytes. Reads return bytes from the current word pointer. The pointer advances after every data byte and survives a repeated start, so a random read is a short write of the word address followed by a read.

Top module: `busfn_router`

## Requirements
- R1: The first byte after a start is decoded as bits [7:4] function code, bits [3:1] device address and bit 0 direction (1 = read). Codes 4'b1001 (limits), 4'b1010 (storage) and 4'b1011 (configuration) are accepted only when bits [3:1] equal `strap`. Acceptance raises `ack` for exactly one cycle, in the cycle after the `rx_valid` cycle. Every other first byte gets no `ack`, and the rest of that transaction is ignored.
- R2: Code 4'b0001 is the alert query. It is accepted only when bit 0 is 1 and an alert is pending. Its bits [3:1] are ignored.
- R3: While `en_n` is high, no byte is acknowledged and nothing is written. Any open transaction is abandoned.
- R4: In a write to the storage space, the second byte loads the word pointer from its low 7 bits. Each later byte is stored at the pointer and acknowledged.
- R5: In the storage space, the word pointer advances by one after each data byte written or each byte taken, and wraps from 127 to 0.
- R6: In a storage read, `tx_byte` shows the word at the pointer, and a `tx_taken` pulse advances the pointer. The pointer is kept across a repeated start.
- R7: In a limit or configuration write, each data byte drives `ext_we` in its `rx_valid` cycle, with `ext_addr` set to the 8-bit pointer, `ext_wdata` set to the byte, and `ext_space` set to 0 for limits or 1 for configuration. The pointer then advances and wraps from 255 to 0.
- R8: In a limit or configuration read, `tx_byte` equals `ext_rdata`, and `ext_re` is high during each `tx_taken` cycle.
- R9: After an accepted alert query, `tx_byte` is {4'b1011, strap, 1'b0}. The following `tx_taken` clears the pending alert, and `alert_n` returns high.
- R10: An `alert_set` pulse drives `alert_n` low from the next cycle.
- R11: After reset, `ack` and `ext_we` are low, `alert_n` is high, and `tx_byte` is 8'hFF.
- R12: Outside a read or alert session, `tx_byte` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low device enable |
| strap | input | 3 | Device address pins |
| alert_set | input | 1 | Raises a pending alert |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ack | output | 1 | Acknowledge for the previous byte |
| tx_taken | input | 1 | Current transmit byte consumed |
| tx_byte | output | 8 | Byte to transmit |
| alert_n | output | 1 | Active-low pending alert |
| ext_space | output | 1 | 0 limit space, 1 configuration space |
| ext_addr | output | 8 | Register word pointer |
| ext_wdata | output | 8 | Register write data |
| ext_we | output | 1 | Register write strobe |
| ext_re | output | 1 | Register read strobe |
| ext_rdata | input | 8 | Register read data |

## Verification
The assertions assume that the upstream byte layer never raises `rx_valid`, `tx_taken`, `bus_start` or `bus_stop` in the same cycle, and that `alert_set` never coincides with the `tx_taken` that answers an alert query. The bench drives each strobe on its own for one cycle, with idle cycles in between. This keeps the ordering rules of the control logic out of play. An exhaustive sweep covers all 256 first bytes for two strap values. Storage writes and reads are long enough to cross the wrap point.

// File: rtl/busfn_pkg.sv
// Shared types and function codes for the serial bus function decoder.
// Assumes byte-wide transfers from an upstream byte layer.
package busfn_pkg;

    localparam int BYTE_W = 8;

    localparam logic [3:0] CODE_ALERT = 4'b0001;
    localparam logic [3:0] CODE_LIMIT = 4'b1001;
    localparam logic [3:0] CODE_MEM   = 4'b1010;
    localparam logic [3:0] CODE_CFG   = 4'b1011;

    typedef enum logic [1:0] {
        FN_ALERT = 2'd0,
        FN_LIMIT = 2'd1,
        FN_MEM   = 2'd2,
        FN_CFG   = 2'd3
    } fn_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WADDR = 3'd2,
        ST_WDATA = 3'd3,
        ST_RDATA = 3'd4,
        ST_ALERT = 3'd5
    } st_e;

endpackage

// File: rtl/busfn_decode.sv
// First-byte decoder: checks the function code and the device address
// against the strap pins, and reports whether the byte is accepted and
// which function space it opens. Purely combinational.
module busfn_decode
    import busfn_pkg::*;
#(
    parameter int STRAP_W = 3
) (
    input  logic [BYTE_W-1:0]  addr_byte,
    input  logic [STRAP_W-1:0] strap,
    input  logic               alert_pending,
    output logic               accept,
    output fn_e                space
);

    logic [3:0] code;
    logic       dev_match;

    assign code      = addr_byte[BYTE_W-1 -: 4];
    assign dev_match = (addr_byte[STRAP_W:1] == strap);

    // Map the function code to a space and an accept decision.
    always_comb begin
        accept = 1'b0;
        space  = FN_MEM;
        unique case (code)
            CODE_ALERT: begin
                space  = FN_ALERT;
                accept = addr_byte[0] && alert_pending;
            end
            CODE_LIMIT: begin
                space  = FN_LIMIT;
                accept = dev_match;
            end
            CODE_MEM: begin
                space  = FN_MEM;
                accept = dev_match;
            end
            CODE_CFG: begin
                space  = FN_CFG;
                accept = dev_match;
            end
            default: begin
                space  = FN_MEM;
                accept = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/busfn_mem.sv
// Word storage array with one synchronous write port and one
// asynchronous read port. Contents are not reset.
module busfn_mem
    import busfn_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] store [DEPTH];

    // Store one word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/busfn_ctrl.sv
// Transaction sequencer: tracks the session state, the word pointer,
// the pending alert and the acknowledge. It assumes start, stop,
// rx_valid and tx_taken come as separate single-cycle strobes.
// DEPTH must be a power of two.
module busfn_ctrl
    import busfn_pkg::*;
#(
    parameter int         STRAP_W   = 3,
    parameter int         MEM_DEPTH = 128,
    parameter logic [3:0] ID_CODE   = 4'b1011,
    localparam int        MEM_AW    = $clog2(MEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               alert_set,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               tx_taken,
    input  logic               dec_accept,
    input  fn_e                dec_space,
    input  logic [BYTE_W-1:0]  mem_rdata,
    input  logic [BYTE_W-1:0]  ext_rdata,
    output logic               alert_pending,
    output logic               ack,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic [BYTE_W-1:0]  ptr,
    output logic               mem_we,
    output logic               ext_space,
    output logic               ext_we,
    output logic               ext_re
);

    st_e               st;
    fn_e               space;
    logic [BYTE_W-1:0] ptr_next;
    logic              rx_ok;
    logic              tx_ok;
    logic              is_ext;

    assign rx_ok  = !en_n && !bus_start && !bus_stop && rx_valid;
    assign tx_ok  = !en_n && !bus_start && !bus_stop && !rx_valid && tx_taken;
    assign is_ext = (space == FN_LIMIT) || (space == FN_CFG);

    // Next pointer: storage wraps at its depth, registers at 8 bits.
    always_comb begin
        if (space == FN_MEM && ptr[MEM_AW-1:0] == MEM_AW'(MEM_DEPTH - 1)) begin
            ptr_next = '0;
        end else begin
            ptr_next = ptr + BYTE_W'(1);
        end
    end

    // Session state, pointer, acknowledge and alert flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            space         <= FN_MEM;
            ptr           <= '0;
            ack           <= 1'b0;
            alert_pending <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (en_n) begin
                st <= ST_IDLE;
            end else if (bus_start) begin
                st <= ST_ADDR;
            end else if (bus_stop) begin
                st <= ST_IDLE;
            end else if (rx_valid) begin
                unique case (st)
                    ST_ADDR: begin
                        if (dec_accept) begin
                            ack   <= 1'b1;
                            space <= dec_space;
                            if (dec_space == FN_ALERT) begin
                                st <= ST_ALERT;
                            end else if (rx_byte[0]) begin
                                st <= ST_RDATA;
                            end else begin
                                st <= ST_WADDR;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_WADDR: begin
                        ack <= 1'b1;
                        st  <= ST_WDATA;
                        if (space == FN_MEM) begin
                            ptr <= BYTE_W'(rx_byte[MEM_AW-1:0]);
                        end else begin
                            ptr <= rx_byte;
                        end
                    end
                    ST_WDATA: begin
                        ack <= 1'b1;
                        ptr <= ptr_next;
                    end
                    default: begin
                    end
                endcase
            end else if (tx_taken) begin
                if (st == ST_RDATA) begin
                    ptr <= ptr_next;
                end else if (st == ST_ALERT) begin
                    alert_pending <= 1'b0;
                    st            <= ST_IDLE;
                end
            end
            if (alert_set) begin
                alert_pending <= 1'b1;
            end
        end
    end

    // Write and read strobes toward storage and the register port.
    always_comb begin
        mem_we = rx_ok && (st == ST_WDATA) && (space == FN_MEM);
        ext_we = rx_ok && (st == ST_WDATA) && is_ext;
        ext_re = tx_ok && (st == ST_RDATA) && is_ext;
    end

    assign ext_space = (space == FN_CFG);

    // Transmit byte source for the current session.
    always_comb begin
        if (st == ST_RDATA) begin
            tx_byte = is_ext ? ext_rdata : mem_rdata;
        end else if (st == ST_ALERT) begin
            tx_byte = {ID_CODE, strap, 1'b0};
        end else begin
            tx_byte = '1;
        end
    end

endmodule

// File: rtl/busfn_router.sv
// Top level of the serial bus function decoder: joins the first-byte
// decoder, the transaction sequencer and the word storage array.
// Assumes a byte layer upstream that supplies single-cycle strobes.
module busfn_router
    import busfn_pkg::*;
#(
    parameter int         STRAP_W   = 3,
    parameter int         MEM_DEPTH = 128,
    parameter logic [3:0] ID_CODE   = 4'b1011,
    localparam int        MEM_AW    = $clog2(MEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               alert_set,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    output logic               ack,
    input  logic               tx_taken,
    output logic [7:0]         tx_byte,
    output logic               alert_n,
    output logic               ext_space,
    output logic [7:0]         ext_addr,
    output logic [7:0]         ext_wdata,
    output logic               ext_we,
    output logic               ext_re,
    input  logic [7:0]         ext_rdata
);

    logic              dec_accept;
    fn_e               dec_space;
    logic              alert_pending;
    logic [BYTE_W-1:0] ptr;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata;

    busfn_decode #(.STRAP_W(STRAP_W)) i_decode (
        .addr_byte     (rx_byte),
        .strap         (strap),
        .alert_pending (alert_pending),
        .accept        (dec_accept),
        .space         (dec_space)
    );

    busfn_ctrl #(
        .STRAP_W   (STRAP_W),
        .MEM_DEPTH (MEM_DEPTH),
        .ID_CODE   (ID_CODE)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_n          (en_n),
        .strap         (strap),
        .alert_set     (alert_set),
        .bus_start     (bus_start),
        .bus_stop      (bus_stop),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .tx_taken      (tx_taken),
        .dec_accept    (dec_accept),
        .dec_space     (dec_space),
        .mem_rdata     (mem_rdata),
        .ext_rdata     (ext_rdata),
        .alert_pending (alert_pending),
        .ack           (ack),
        .tx_byte       (tx_byte),
        .ptr           (ptr),
        .mem_we        (mem_we),
        .ext_space     (ext_space),
        .ext_we        (ext_we),
        .ext_re        (ext_re)
    );

    busfn_mem #(.DEPTH(MEM_DEPTH)) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr[MEM_AW-1:0]),
        .wdata (rx_byte),
        .raddr (ptr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    assign alert_n   = !alert_pending;
    assign ext_addr  = ptr;
    assign ext_wdata = rx_byte;

endmodule

// File: rtl/busfn_router_chk.sv
// Checker for busfn_router: port-level timing rules on acknowledge,
// enable gating, register writes and the alert line.
module busfn_router_chk (
    input logic clk,
    input logic rst_n,
    input logic en_n,
    input logic rx_valid,
    input logic ack,
    input logic tx_taken,
    input logic alert_set,
    input logic alert_n,
    input logic ext_we
);

    logic past_ok;

    // Marks that one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ack |-> $past(rx_valid)); // R1

    AST_DISABLED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(en_n) |-> !ack); // R3

    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we |-> (!en_n && rx_valid)); // R7

    AST_ALERT_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(alert_n) |-> $past(tx_taken)); // R9

    AST_ALERT_RAISE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $fell(alert_n) |-> $past(alert_set)); // R10

endmodule

bind busfn_router busfn_router_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_n      (en_n),
    .rx_valid  (rx_valid),
    .ack       (ack),
    .tx_taken  (tx_taken),
    .alert_set (alert_set),
    .alert_n   (alert_n),
    .ext_we    (ext_we)
);

// File: tb/test_busfn_router.sv
module test_busfn_router;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       alert_set = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack;
    logic       tx_taken = 1'b0;
    logic [7:0] tx_byte;
    logic       alert_n;
    logic       ext_space;
    logic [7:0] ext_addr;
    logic [7:0] ext_wdata;
    logic       ext_we;
    logic       ext_re;
    logic [7:0] ext_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [128];
    logic       cap_we, cap_space, cap_re;
    logic [7:0] cap_addr, cap_wdata;

    always #5 clk = ~clk;
    assign ext_rdata = ext_addr ^ 8'h5A;

    busfn_router i_busfn_router (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .strap(strap),
        .alert_set(alert_set), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .ack(ack),
        .tx_taken(tx_taken), .tx_byte(tx_byte), .alert_n(alert_n),
        .ext_space(ext_space), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_we(ext_we), .ext_re(ext_re), .ext_rdata(ext_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_start;
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop;
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic a);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        #1;
        cap_we = ext_we; cap_addr = ext_addr; cap_wdata = ext_wdata; cap_space = ext_space;
        @(negedge clk); rx_valid = 1'b0;
        a = ack;
    endtask

    task automatic take(output logic [7:0] d);
        @(negedge clk); d = tx_byte; tx_taken = 1'b1;
        #1 cap_re = ext_re;
        @(negedge clk); tx_taken = 1'b0;
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 / R12 reset state
        chk("R11 ack", 8'(ack), 8'h0);
        chk("R11 alert_n", 8'(alert_n), 8'h1);
        chk("R11 ext_we", 8'(ext_we), 8'h0);
        chk("R12 tx idle", tx_byte, 8'hFF);

        // R1 / R2 exhaustive first-byte sweep, no alert pending
        for (int s = 0; s < 2; s++) begin
            strap = (s == 0) ? 3'b101 : 3'b010;
            for (int b = 0; b < 256; b++) begin
                logic [3:0] c;
                logic exp_a;
                c = 4'(b >> 4);
                exp_a = (c == 4'h9 || c == 4'hA || c == 4'hB) && (3'(b >> 1) == strap);
                do_start;
                send(8'(b), a);
                chk("R1 first byte ack", 8'(a), 8'(exp_a));
                do_stop;
            end
        end
        strap = 3'b101;

        // R3 enable high: address byte refused
        en_n = 1'b1;
        do_start;
        send({4'hA, strap, 1'b0}, a);
        chk("R3 nack when disabled", 8'(a), 8'h0);
        en_n = 1'b0;
        do_stop;

        // R4 / R5 storage write crossing the wrap point
        do_start;
        send({4'hA, strap, 1'b0}, a);
        send(8'd5, a);
        chk("R4 word address ack", 8'(a), 8'h1);
        for (int i = 0; i < 130; i++) begin
            d = 8'((i * 37 + 11) & 255);
            send(d, a);
            chk("R4 data ack", 8'(a), 8'h1);
            model[(5 + i) % 128] = d;
        end
        do_stop;

        // R6 / R5 random read across the wrap with repeated start
        do_start;
        send({4'hA, strap, 1'b0}, a);
        send(8'd120, a);
        do_start;
        send({4'hA, strap, 1'b1}, a);
        chk("R6 read address ack", 8'(a), 8'h1);
        for (int i = 0; i < 16; i++) begin
            take(d);
            chk("R5 R6 read wrap", d, model[(120 + i) % 128]);
        end
        do_stop;
        chk("R12 tx after stop", tx_byte, 8'hFF);

        // R3 enable raised mid-write: byte ignored, contents unchanged
        do_start;
        send({4'hA, strap, 1'b0}, a);
        send(8'd40, a);
        en_n = 1'b1;
        send(8'hEE, a);
        chk("R3 data nack when disabled", 8'(a), 8'h0);
        en_n = 1'b0;
        do_stop;

        // R6 full storage read from word 0
        do_start;
        send({4'hA, strap, 1'b0}, a);
        send(8'd0, a);
        do_start;
        send({4'hA, strap, 1'b1}, a);
        for (int i = 0; i < 128; i++) begin
            take(d);
            chk("R6 full read", d, model[i]);
        end
        do_stop;

        // R7 limit-space write
        do_start;
        send({4'h9, strap, 1'b0}, a);
        send(8'h10, a);
        for (int i = 0; i < 3; i++) begin
            send(8'(8'hC0 + i), a);
            chk("R7 limit we", 8'(cap_we), 8'h1);
            chk("R7 limit addr", cap_addr, 8'(8'h10 + i));
            chk("R7 limit wdata", cap_wdata, 8'(8'hC0 + i));
            chk("R7 limit space", 8'(cap_space), 8'h0);
        end
        do_stop;

        // R7 configuration-space write with 8-bit pointer wrap
        do_start;
        send({4'hB, strap, 1'b0}, a);
        send(8'hFF, a);
        for (int i = 0; i < 2; i++) begin
            send(8'(8'h33 + i), a);
            chk("R7 cfg we", 8'(cap_we), 8'h1);
            chk("R7 cfg addr wrap", cap_addr, 8'(8'hFF + i));
            chk("R7 cfg space", 8'(cap_space), 8'h1);
        end
        do_stop;

        // R8 configuration-space read
        do_start;
        send({4'hB, strap, 1'b0}, a);
        send(8'h20, a);
        do_start;
        send({4'hB, strap, 1'b1}, a);
        for (int i = 0; i < 3; i++) begin
            take(d);
            chk("R8 ext read data", d, 8'(8'h20 + i) ^ 8'h5A);
            chk("R8 ext_re", 8'(cap_re), 8'h1);
        end
        do_stop;

        // R10 / R2 / R9 alert flow
        @(negedge clk); alert_set = 1'b1;
        @(negedge clk); alert_set = 1'b0;
        chk("R10 alert_n low", 8'(alert_n), 8'h0);
        do_start;
        send({4'h1, 3'b000, 1'b0}, a);
        chk("R2 alert write nack", 8'(a), 8'h0);
        do_stop;
        do_start;
        send({4'h1, 3'b111, 1'b1}, a);
        chk("R2 alert ack", 8'(a), 8'h1);
        chk("R9 alert byte", tx_byte, {4'hB, strap, 1'b0});
        take(d);
        chk("R9 alert cleared", 8'(alert_n), 8'h1);
        do_stop;
        do_start;
        send({4'h1, 3'b111, 1'b1}, a);
        chk("R2 no pending nack", 8'(a), 8'h0);
        do_stop;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule